// File: doc/BRIEF.md
# SRAM Page Write-Protect Guard

This block sits in front of a 32 KB on-chip SRAM that is divided into 32 pages of 1 KB each. It holds a 32-bit protection mask with one bit per page. Software can add protection to any page at any time, but no software write can remove it. Only a system reset returns the mask to all zeros.

Each SRAM write is checked against the mask bit of the page it addresses. A write to an unprotected page passes through unchanged. A write to a protected page reaches the array with its write enable and all byte strobes forced low. It also sets a sticky error flag, which can drive an interrupt. Reads are never checked.

A small two-entry configuration port gives access to the mask and to a status word. The status word carries the error flag and the interrupt enable. The SRAM array itself is outside this block.

Top module: `sram_wp_guard`

## Requirements
- R1: After reset the protection mask reads 0, the error flag reads 0, the interrupt enable reads 0 and `irq` is low.
- R2: A configuration write with `cfg_addr`=0 ORs `cfg_wdata` into the mask, with bit n protecting page n. Zero bits in the data change nothing, so writing 0 leaves the mask as it was.
- R3: No configuration write ever clears a mask bit. Only reset clears one.
- R4: The page index is `mem_addr[14:10]`. A write (`mem_we`=1) to a page whose mask bit is 1 gives `gated_we`=0, `gated_be`=0 and `wr_blocked`=1 in the same cycle.
- R5: A write to a page whose mask bit is 0 passes `mem_we` and `mem_be` unchanged to `gated_we` and `gated_be`, with `wr_blocked`=0.
- R6: When `mem_we`=0 (a read), `wr_blocked` stays 0, `gated_be` equals `mem_be`, and the error flag is not set, whatever the mask holds.
- R7: A blocked write sets the error flag from the next clock edge on. The flag stays set until it is cleared.
- R8: Writing the status word (`cfg_addr`=1) with bit 0 = 1 clears the error flag, and writing bit 0 = 0 leaves it alone. If a clear and a blocked write happen in the same cycle, the flag ends up set.
- R9: Status bit 1 is the interrupt enable, which software can read and write. `irq` is high exactly when both the error flag and the enable are 1.
- R10: When a mask write and an SRAM write happen in the same cycle, the SRAM write is checked against the mask value from before that write.
- R11: With `cfg_write`=0, `cfg_rdata` returns the mask when `cfg_addr`=0. When `cfg_addr`=1 it returns the status word: bit 0 is the error flag, bit 1 is the enable, and every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset; the only way to clear protection |
| cfg_write | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Selects the word: 0 = protection mask, 1 = status |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected configuration word |
| mem_addr | input | 15 | SRAM byte address |
| mem_we | input | 1 | SRAM write enable from the requester |
| mem_be | input | 4 | SRAM byte strobes from the requester |
| gated_we | output | 1 | Write enable forwarded to the SRAM |
| gated_be | output | 4 | Byte strobes forwarded to the SRAM |
| wr_blocked | output | 1 | High in a cycle whose write is being suppressed |
| wr_err | output | 1 | Sticky error flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the properties that must always hold. Mask bits never fall. A blocked write never reaches the array with any strobe. Reads are never blocked. Unprotected writes pass unchanged. A block always sets the error flag one edge later, and the interrupt never rises without the flag. Some behaviours can only be shown by the bench's scenarios: that the page index really comes from address bits 14 to 10, including the top and bottom pages; that a same-cycle mask write does not affect the write being checked; that a simultaneous clear loses to a new block; and that reset is the only way to remove protection.

// File: rtl/sram_wp_pkg.sv
package sram_wp_pkg;
  // configuration word selector
  typedef enum logic {
    CFG_MASK = 1'b0,
    CFG_STAT = 1'b1
  } cfg_sel_e;

  // status word bit positions
  localparam int unsigned STAT_ERR_BIT = 0;
  localparam int unsigned STAT_IEN_BIT = 1;
endpackage

// File: rtl/wp_mask_reg.sv
module wp_mask_reg #(
  parameter int unsigned NUM_PAGES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [NUM_PAGES-1:0] set_bits,
  output logic [NUM_PAGES-1:0] mask
);
  // bits can only be added; reset is the sole way down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (set_en) mask <= mask | set_bits;
  end

  // R3: no bit that was set may fall while out of reset
  assert_mask_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask & $past(mask)) == $past(mask)));

  // R2: every requested bit is present after the write
  assert_mask_takes_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int unsigned NUM_PAGES  = 32,
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned STRB_W     = 4,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PIDX_W    = $clog2(NUM_PAGES),
  localparam int unsigned ADDR_W    = OFS_W + PIDX_W
) (
  input  logic [NUM_PAGES-1:0] mask,
  input  logic                 mem_we,
  input  logic [ADDR_W-1:0]    mem_addr,
  input  logic [STRB_W-1:0]    mem_be,
  output logic                 gated_we,
  output logic [STRB_W-1:0]    gated_be,
  output logic                 blocked
);
  function automatic logic [PIDX_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  logic [PIDX_W-1:0] page_idx;
  logic              page_locked;

  always_comb begin
    page_idx    = page_of(mem_addr);
    page_locked = mask[page_idx];
    blocked     = mem_we & page_locked;
    gated_we    = mem_we & ~blocked;
    gated_be    = blocked ? '0 : mem_be;
  end
endmodule

// File: rtl/wp_err_ctrl.sv
module wp_err_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic blocked,
  input  logic stat_wr,
  input  logic clr_req,
  input  logic ien_val,
  output logic err,
  output logic ien,
  output logic irq
);
  // a new block outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
      ien <= 1'b0;
    end else begin
      if (blocked)                err <= 1'b1;
      else if (stat_wr && clr_req) err <= 1'b0;
      if (stat_wr)                ien <= ien_val;
    end
  end

  assign irq = err & ien;

  // R7: a block is always recorded
  assert_err_after_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> err);
endmodule

// File: rtl/sram_wp_guard.sv
module sram_wp_guard #(
  parameter int unsigned NUM_PAGES  = 32,
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned STRB_W     = 4,
  parameter int unsigned CFG_W      = 32,
  localparam int unsigned ADDR_W    = $clog2(NUM_PAGES) + $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_write,
  input  logic              cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_we,
  input  logic [STRB_W-1:0] mem_be,
  output logic              gated_we,
  output logic [STRB_W-1:0] gated_be,
  output logic              wr_blocked,
  output logic              wr_err,
  output logic              irq
);
  import sram_wp_pkg::*;

  logic [NUM_PAGES-1:0] mask;
  logic [CFG_W-1:0]     mask_word;
  logic [CFG_W-1:0]     stat_word;
  logic                 mask_wr;
  logic                 stat_wr;
  logic                 ien;

  assign mask_wr = cfg_write && (cfg_sel_e'(cfg_addr) == CFG_MASK);
  assign stat_wr = cfg_write && (cfg_sel_e'(cfg_addr) == CFG_STAT);

  wp_mask_reg #(.NUM_PAGES(NUM_PAGES)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (mask_wr),
    .set_bits (cfg_wdata[NUM_PAGES-1:0]),
    .mask     (mask)
  );

  wp_gate #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .STRB_W(STRB_W)) u_gate (
    .mask     (mask),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .gated_we (gated_we),
    .gated_be (gated_be),
    .blocked  (wr_blocked)
  );

  wp_err_ctrl u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .blocked (wr_blocked),
    .stat_wr (stat_wr),
    .clr_req (cfg_wdata[STAT_ERR_BIT]),
    .ien_val (cfg_wdata[STAT_IEN_BIT]),
    .err     (wr_err),
    .ien     (ien),
    .irq     (irq)
  );

  // pad the mask up to the register width when there are fewer pages
  generate
    if (NUM_PAGES < CFG_W) begin : g_pad
      assign mask_word = {{(CFG_W-NUM_PAGES){1'b0}}, mask};
    end else begin : g_full
      assign mask_word = mask;
    end
  endgenerate

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_ERR_BIT] = wr_err;
    stat_word[STAT_IEN_BIT] = ien;
    cfg_rdata = (cfg_sel_e'(cfg_addr) == CFG_STAT) ? stat_word : mask_word;
  end

  // R4: a blocked write must carry no strobe at all
  assert_block_kills_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> (!gated_we && gated_be == '0));

  // R5: an allowed write is forwarded untouched
  assert_unprot_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !wr_blocked) |-> (gated_we && gated_be == mem_be));

  // R6: reads are never blocked
  assert_read_never_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> !wr_blocked);

  // R9: the interrupt needs the error flag
  assert_irq_needs_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wr_err);
endmodule

// File: tb/sram_wp_guard_bench.sv
`timescale 1ns/1ps
module sram_wp_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_write = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [14:0] mem_addr = '0;
  logic        mem_we = 1'b0;
  logic [3:0]  mem_be = '0;
  logic        gated_we;
  logic [3:0]  gated_be;
  logic        wr_blocked;
  logic        wr_err;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sram_wp_guard u_sram_wp_guard (
    .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .gated_we(gated_we), .gated_be(gated_be),
    .wr_blocked(wr_blocked), .wr_err(wr_err), .irq(irq)
  );

  // row: cfg_wr, cfg_addr, wdata[32], we, addr[15], be[4] | exp_we, exp_be[4], exp_blk
  localparam int NV = 11;
  localparam logic [59:0] VEC [NV] = '{
    {1'b0,1'b0,32'h0,          1'b1,15'h0000,4'hF, 1'b1,4'hF,1'b0}, // R5 page 0 open
    {1'b1,1'b0,32'h0000_0005,  1'b1,15'h0000,4'h3, 1'b1,4'h3,1'b0}, // R10 old mask used
    {1'b0,1'b0,32'h0,          1'b1,15'h0004,4'hF, 1'b0,4'h0,1'b1}, // R4 page 0 locked
    {1'b0,1'b0,32'h0,          1'b1,15'h0400,4'hC, 1'b1,4'hC,1'b0}, // R5 page 1 open
    {1'b0,1'b0,32'h0,          1'b1,15'h0BFC,4'h1, 1'b0,4'h0,1'b1}, // R4 page 2 locked
    {1'b0,1'b0,32'h0,          1'b0,15'h0BFC,4'hF, 1'b0,4'hF,1'b0}, // R6 read of locked page
    {1'b1,1'b0,32'h0,          1'b0,15'h0000,4'h0, 1'b0,4'h0,1'b0}, // R2 zero write
    {1'b0,1'b0,32'h0,          1'b1,15'h0010,4'hF, 1'b0,4'h0,1'b1}, // R2 page 0 still locked
    {1'b1,1'b0,32'h8000_0000,  1'b0,15'h0000,4'h0, 1'b0,4'h0,1'b0}, // R2 add page 31
    {1'b0,1'b0,32'h0,          1'b1,15'h7FFF,4'h8, 1'b0,4'h0,1'b1}, // R4 top page locked
    {1'b0,1'b0,32'h0,          1'b1,15'h7BFF,4'h2, 1'b1,4'h2,1'b0}  // R5 page 30 open
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_write = 1'b0; cfg_wdata = '0; mem_we = 1'b0; mem_be = '0;
  endtask

  task automatic read_cfg(input logic sel, output logic [31:0] v);
    cfg_write = 1'b0; cfg_addr = sel; #1; v = cfg_rdata;
  endtask

  task automatic cfg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk); cfg_write = 1'b1; cfg_addr = sel; cfg_wdata = d;
    @(posedge clk); @(negedge clk); idle();
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_cfg(1'b0, v); check(v == 32'h0, "R1 mask", v, 32'h0);
    read_cfg(1'b1, v); check(v == 32'h0, "R1 status", v, 32'h0);
    check(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [59:0] r;
      string tag;
      r = VEC[i];
      @(negedge clk);
      cfg_write = r[59]; cfg_addr = r[58]; cfg_wdata = r[57:26];
      mem_we = r[25]; mem_addr = r[24:10]; mem_be = r[9:6];
      #1;
      tag = (r[59] && r[25]) ? "R10" : r[0] ? "R4" : r[25] ? "R5" : "R6";
      check({gated_we, gated_be, wr_blocked} == r[5:0], tag,
            {26'b0, gated_we, gated_be, wr_blocked}, {26'b0, r[5:0]});
      @(posedge clk);
    end
    @(negedge clk); idle();

    // R11 read back of accumulated mask (R2/R3)
    read_cfg(1'b0, v); check(v == 32'h8000_0005, "R11 mask readback", v, 32'h8000_0005);
    // R7 sticky error from earlier blocks, irq off
    read_cfg(1'b1, v); check(v == 32'h1, "R7 err sticky", v, 32'h1);
    check(irq == 1'b0, "R9 irq disabled", {31'b0, irq}, 32'h0);

    // R8 bit0=0 leaves flag; R9 enable raises irq
    cfg_wr(1'b1, 32'h2);
    read_cfg(1'b1, v); check(v == 32'h3, "R8 zero keeps err", v, 32'h3);
    check(irq == 1'b1, "R9 irq on", {31'b0, irq}, 32'h1);

    // R8 clear
    cfg_wr(1'b1, 32'h3);
    read_cfg(1'b1, v); check(v == 32'h2, "R8 clear", v, 32'h2);
    check(irq == 1'b0, "R9 irq follows err", {31'b0, irq}, 32'h0);

    // R6 read of locked page does not set err
    @(negedge clk); mem_we = 1'b0; mem_addr = 15'h0000; mem_be = 4'hF;
    @(posedge clk); @(negedge clk); idle();
    read_cfg(1'b1, v); check(v == 32'h2, "R6 read no err", v, 32'h2);

    // R7 single block sets err at next edge
    @(negedge clk); mem_we = 1'b1; mem_addr = 15'h0800; mem_be = 4'hF;
    @(posedge clk); @(negedge clk); idle();
    read_cfg(1'b1, v); check(v == 32'h3, "R7 err set", v, 32'h3);

    // R8 clear and block together: set wins
    cfg_wr(1'b1, 32'h3);
    @(negedge clk); cfg_write = 1'b1; cfg_addr = 1'b1; cfg_wdata = 32'h3;
    mem_we = 1'b1; mem_addr = 15'h7C00; mem_be = 4'h1;
    @(posedge clk); @(negedge clk); idle();
    read_cfg(1'b1, v); check(v == 32'h3, "R8 set beats clear", v, 32'h3);

    // R3 writes of zero never drop bits
    cfg_wr(1'b0, 32'h0);
    read_cfg(1'b0, v); check(v == 32'h8000_0005, "R3 no clear", v, 32'h8000_0005);

    // R1/R3 reset is the only way out
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    read_cfg(1'b0, v); check(v == 32'h0, "R3 reset clears mask", v, 32'h0);
    read_cfg(1'b1, v); check(v == 32'h0, "R1 reset clears status", v, 32'h0);
    @(negedge clk); mem_we = 1'b1; mem_addr = 15'h0000; mem_be = 4'h5; #1;
    check({gated_we, gated_be, wr_blocked} == 6'b1_0101_0, "R5 open after reset",
          {26'b0, gated_we, gated_be, wr_blocked}, 32'h2A);
    @(negedge clk); idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule